// File: doc/BRIEF.md
# Bus error capture and logging unit

This unit sits beside a node's interface to a 128-bit system bus. The bus carries four 32-bit longwords per cycle. The unit watches command/address (C/A) cycles, outgoing write-data cycles and returned read data. It checks parity on the even longwords and records each fault in a status register whose bits software clears by writing a one.

Next to the status register sits a 64-bit capture register. It holds the C/A contents of the latest cycle this node started, or of a C/A cycle that carried a parity fault. Once a primary fault is logged, the capture register freezes. Later faults that cannot be captured set "missed" flags, and those flags never hold the freeze. A diagnostic input from a companion chip sets a flag of its own, and that flag does not freeze the capture either.

Both registers are read and written through a small synchronous CSR port. Reads return data one cycle after the address is presented.

Top module: `bus_err_log`

## Requirements
- R1: After reset every status bit is zero and the capture register holds zero, so the capture offset reads back 64'h0000_0003_0000_0003.
- R2: A CSR write to the status offset (0) clears each status bit whose write-data bit is one and leaves the bits written zero unchanged. If a hardware set and a clear reach the same bit in one cycle, the bit ends up set.
- R3: Parity is even over each 32-bit longword with its own parity bit (lw_par[i] goes with lw_data[32i+31:32i]). Only longwords 0 and 2 are checked, and faults on longwords 1 and 3 never set any flag.
- R4: Status bit 0 (read-data fault) is set when rd_valid, is_cmdr and a parity fault all occur in one cycle. Returned data seen while not commander sets nothing.
- R5: A parity fault on a write-data cycle (wd_valid) seen as responder or bystander sets status bit 1 when no primary bit is set. When a primary bit is set, it sets status bit 3 (write missed) instead.
- R6: A parity fault on any C/A cycle (ca_valid), whoever the commander, sets status bit 2 when no primary bit is set. When a primary bit is set, it sets status bit 4 (C/A missed) instead.
- R7: A C/A cycle that this node starts without ack sets bit 4 and is not captured. A write-data cycle that this node starts without ack sets bit 3.
- R8: While status bits 2:0 (primary) are all zero, the capture register loads lw_data[63:0] on each acked own C/A cycle and on each C/A cycle with a parity fault. While any primary bit is set, it holds its value. Bits 3, 4 and 5 have no effect on this.
- R9: A read of the capture offset (1) returns ones in bits 33:32 and 1:0, whatever was captured.
- R10: The diag_err input sets status bit 5 and does not freeze the capture register.
- R11: csr_rdata shows, one cycle after csr_addr is presented, the status register (bits 5:0, upper bits zero) for offset 0, the capture register for offset 1, and zero for any other offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ca_valid | input | 1 | C/A phase strobe |
| wd_valid | input | 1 | Write-data phase strobe |
| rd_valid | input | 1 | Returned read-data strobe |
| is_cmdr | input | 1 | This node is commander of the current cycle |
| is_resp | input | 1 | This node is responder |
| is_byst | input | 1 | This node is a bystander |
| ack | input | 1 | Cycle acknowledged, valid with the strobe |
| lw_data | input | 128 | Four longwords, longword i in bits 32i+31:32i |
| lw_par | input | 4 | One even-parity bit per longword |
| diag_err | input | 1 | Diagnostic fault from companion chip |
| csr_addr | input | 4 | CSR offset |
| csr_we | input | 1 | CSR write enable |
| csr_wdata | input | 64 | CSR write data |
| csr_rdata | output | 64 | CSR read data, one cycle latency |

## Verification
Two events can fall in one cycle: a hardware fault sets a status bit while software writes a one to clear that same bit. The bench provokes this by raising a read-data parity fault in the very cycle it writes the clear. It judges the result by reading the status offset afterwards and expecting the bit still set. It also clears the primary bits and, in the following cycles, starts a C/A cycle. This shows that capture resumes as soon as the cleared status is visible. A behavioural model compares csr_rdata on every clock across all of these sequences.

// File: rtl/bus_err_log.sv
module bus_err_log #(
  parameter int LW_W   = 32,
  parameter int N_LW   = 4,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STAT_OFS = 0,
  parameter logic [ADDR_W-1:0] CAP_OFS  = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ca_valid,
  input  logic                 wd_valid,
  input  logic                 rd_valid,
  input  logic                 is_cmdr,
  input  logic                 is_resp,
  input  logic                 is_byst,
  input  logic                 ack,
  input  logic [N_LW*LW_W-1:0] lw_data,
  input  logic [N_LW-1:0]      lw_par,
  input  logic                 diag_err,
  input  logic [ADDR_W-1:0]    csr_addr,
  input  logic                 csr_we,
  input  logic [2*LW_W-1:0]    csr_wdata,
  output logic [2*LW_W-1:0]    csr_rdata
);
  localparam int CAP_W = 2*LW_W;
  localparam int ST_W  = 6;
  localparam int B_RD  = 0;
  localparam int B_WD  = 1;
  localparam int B_CA  = 2;
  localparam int B_WDM = 3;
  localparam int B_CAM = 4;
  localparam int B_DG  = 5;
  localparam logic [CAP_W-1:0] SBO_MASK = (CAP_W'(3) << LW_W) | CAP_W'(3);

  logic [ST_W-1:0]  st_q, st_set, st_clr;
  logic [CAP_W-1:0] cap_q;
  logic [N_LW-1:0]  lw_bad;
  logic             bad_even, frozen, cap_load;

  genvar g;
  generate
    for (g = 0; g < N_LW; g++) begin : g_lane
      if (g % 2 == 0) begin : g_chk
        assign lw_bad[g] = ^{lw_par[g], lw_data[g*LW_W +: LW_W]};
      end else begin : g_skip
        logic unused_lane;
        assign unused_lane = ^{lw_par[g], lw_data[g*LW_W +: LW_W]};
        assign lw_bad[g] = 1'b0;
      end
    end
  endgenerate

  logic unused_wdata;
  assign unused_wdata = ^csr_wdata[CAP_W-1:ST_W];

  assign bad_even = |lw_bad;
  assign frozen   = |st_q[B_CA:B_RD];

  assign st_set[B_RD]  = rd_valid && is_cmdr && bad_even;
  assign st_set[B_WD]  = wd_valid && (is_resp || is_byst) && bad_even && !frozen;
  assign st_set[B_CA]  = ca_valid && bad_even && !frozen;
  assign st_set[B_WDM] = wd_valid && ((is_resp || is_byst) && bad_even && frozen || is_cmdr && !ack);
  assign st_set[B_CAM] = ca_valid && (bad_even && frozen || is_cmdr && !ack);
  assign st_set[B_DG]  = diag_err;

  assign st_clr   = (csr_we && csr_addr == STAT_OFS) ? csr_wdata[ST_W-1:0] : '0;
  assign cap_load = ca_valid && !frozen && (is_cmdr && ack || bad_even);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= '0;
      cap_q     <= '0;
      csr_rdata <= '0;
    end else begin
      st_q <= (st_q & ~st_clr) | st_set;
      if (cap_load) cap_q <= lw_data[CAP_W-1:0];
      if (csr_addr == STAT_OFS)
        csr_rdata <= {{(CAP_W-ST_W){1'b0}}, st_q};
      else if (csr_addr == CAP_OFS)
        csr_rdata <= cap_q | SBO_MASK;
      else
        csr_rdata <= '0;
    end
  end

  p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|st_q[B_CA:B_RD]) |=> $stable(cap_q));

  p_rd_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[B_RD]) |-> $past(rd_valid && is_cmdr));

  p_ca_unack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ca_valid && is_cmdr && !ack) |=> st_q[B_CAM]);

  p_diag_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[B_DG]) |-> $past(diag_err));

  p_sbo_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(csr_addr) == CAP_OFS) |-> (&csr_rdata[1:0] && &csr_rdata[LW_W+1:LW_W]));

  p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    diag_err |=> st_q[B_DG]);
endmodule

// File: tb/tb_bus_err_log.sv
module tb_bus_err_log;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] MASK = 64'h0000_0003_0000_0003;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, ca_valid, wd_valid, rd_valid, is_cmdr, is_resp, is_byst, ack, diag_err, csr_we;
  logic [127:0] lw_data;
  logic [3:0]   lw_par;
  logic [3:0]   csr_addr;
  logic [63:0]  csr_wdata, csr_rdata;

  bus_err_log dut (
    .clk(clk), .rst_n(rst_n), .ca_valid(ca_valid), .wd_valid(wd_valid), .rd_valid(rd_valid),
    .is_cmdr(is_cmdr), .is_resp(is_resp), .is_byst(is_byst), .ack(ack), .lw_data(lw_data),
    .lw_par(lw_par), .diag_err(diag_err), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata));

  int checks = 0, failures = 0;
  bit done = 0;
  string tag = "R1";
  logic [5:0]  m_st;
  logic [63:0] m_cap, m_rd;

  function automatic logic [3:0] gpar(logic [127:0] d);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ^d[32*i +: 32];
    return p;
  endfunction

  task automatic quiet();
    ca_valid = 0; wd_valid = 0; rd_valid = 0; is_cmdr = 0; is_resp = 0; is_byst = 0;
    ack = 1; diag_err = 0; csr_we = 0; csr_wdata = '0; csr_addr = 4'd0;
  endtask

  task automatic step();
    bit frz, bad;
    logic [5:0] s, c;
    logic [63:0] nrd, ncap;
    frz = |m_st[2:0];
    bad = (^{lw_par[0], lw_data[31:0]}) || (^{lw_par[2], lw_data[95:64]});
    s = '0;
    if (rd_valid && is_cmdr && bad) s[0] = 1;
    if (wd_valid && (is_resp || is_byst) && bad) begin if (frz) s[3] = 1; else s[1] = 1; end
    if (wd_valid && is_cmdr && !ack) s[3] = 1;
    if (ca_valid && bad) begin if (frz) s[4] = 1; else s[2] = 1; end
    if (ca_valid && is_cmdr && !ack) s[4] = 1;
    if (diag_err) s[5] = 1;
    c = (csr_we && csr_addr == 4'd0) ? csr_wdata[5:0] : 6'd0;
    nrd = (csr_addr == 4'd0) ? {58'd0, m_st} : (csr_addr == 4'd1) ? (m_cap | MASK) : 64'd0;
    ncap = m_cap;
    if (ca_valid && !frz && ((is_cmdr && ack) || bad)) ncap = lw_data[63:0];
    @(posedge clk);
    m_st = (m_st & ~c) | s; m_cap = ncap; m_rd = nrd;
    @(negedge clk);
    checks++;
    if (csr_rdata !== m_rd) begin
      failures++;
      $display("FAIL %s model compare: actual %h expected %h", tag, csr_rdata, m_rd);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [63:0] exp, input string t);
    quiet(); csr_addr = a; step();
    checks++;
    if (csr_rdata !== exp) begin
      failures++;
      $display("FAIL %s read %0d: actual %h expected %h", t, a, csr_rdata, exp);
    end
  endtask

  task automatic wr(input logic [5:0] v);
    quiet(); csr_we = 1; csr_addr = 4'd0; csr_wdata = {58'd0, v}; step(); quiet();
  endtask

  task automatic cyc(input bit ca, input bit wd, input bit rdv, input bit c, input bit r,
                     input bit b, input bit a, input logic [127:0] d, input logic [3:0] flip);
    quiet();
    ca_valid = ca; wd_valid = wd; rd_valid = rdv; is_cmdr = c; is_resp = r; is_byst = b; ack = a;
    lw_data = d; lw_par = gpar(d) ^ flip;
    step(); quiet();
  endtask

  localparam logic [127:0] D1 = 128'h1357_9BDF_0000_0007_8421_0001_0000_00E0;
  localparam logic [127:0] D2 = 128'h0F0F_0F0E_1111_1113_ABCD_EF01_2345_6789;
  localparam logic [127:0] D3 = 128'h0000_0001_8000_0000_DEAD_BEEF_CAFE_F00D;
  localparam logic [127:0] D4 = 128'h7777_7777_5555_5555_0123_4567_89AB_CDEF;

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    quiet(); lw_data = '0; lw_par = '0; rst_n = 0;
    m_st = '0; m_cap = '0; m_rd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    tag = "R1"; rd(4'd0, 64'd0, "R1"); rd(4'd1, MASK, "R1");

    tag = "R3";
    cyc(0,0,1, 1,0,0,1, D1, 4'b0000); rd(4'd0, 64'd0, "R3 good parity");
    cyc(0,0,1, 1,0,0,1, D1, 4'b0010); rd(4'd0, 64'd0, "R3 lw1 ignored");
    cyc(0,0,1, 1,0,0,1, D1, 4'b1000); rd(4'd0, 64'd0, "R3 lw3 ignored");
    tag = "R4";
    cyc(0,0,1, 0,1,0,1, D1, 4'b0001); rd(4'd0, 64'd0, "R4 not commander");
    cyc(0,0,1, 1,0,0,1, D1, 4'b0100); rd(4'd0, 64'd1, "R4 lw2 fault");

    tag = "R2";
    wr(6'd0); rd(4'd0, 64'd1, "R2 write zero");
    quiet(); csr_we = 1; csr_wdata = 64'd1; rd_valid = 1; is_cmdr = 1;
    lw_data = D2; lw_par = gpar(D2) ^ 4'b0001; step(); quiet();
    rd(4'd0, 64'd1, "R2 set wins");
    wr(6'd1); rd(4'd0, 64'd0, "R2 clear");

    tag = "R8";
    cyc(1,0,0, 1,0,0,1, D1, 4'b0000); rd(4'd1, D1[63:0] | MASK, "R8 capture");
    cyc(1,0,0, 1,0,0,1, D2, 4'b0000); rd(4'd1, D2[63:0] | MASK, "R8 recapture");
    cyc(0,0,1, 1,0,0,1, D1, 4'b0001);
    cyc(1,0,0, 1,0,0,1, D3, 4'b0000); rd(4'd1, D2[63:0] | MASK, "R8 frozen");
    rd(4'd0, 64'd1, "R8 no miss on clean cycle");
    wr(6'd1);
    cyc(1,0,0, 1,0,0,1, D3, 4'b0000); rd(4'd1, D3[63:0] | MASK, "R8 resume");
    tag = "R9"; rd(4'd1, D3[63:0] | MASK, "R9");

    tag = "R5";
    cyc(0,1,0, 0,1,0,1, D4, 4'b0001); rd(4'd0, 64'h2, "R5 write fault");
    cyc(0,1,0, 0,0,1,1, D4, 4'b0100); rd(4'd0, 64'hA, "R5 write missed");
    wr(6'h3F); rd(4'd0, 64'd0, "R5 cleared");

    tag = "R6";
    cyc(1,0,0, 0,0,1,1, D4, 4'b0100); rd(4'd0, 64'h4, "R6 C/A fault");
    rd(4'd1, D4[63:0] | MASK, "R6 fault captured");
    cyc(1,0,0, 0,0,1,1, D1, 4'b0001); rd(4'd0, 64'h14, "R6 C/A missed");
    rd(4'd1, D4[63:0] | MASK, "R6 frozen");
    wr(6'h3F);

    tag = "R7";
    cyc(1,0,0, 1,0,0,0, D1, 4'b0000); rd(4'd0, 64'h10, "R7 C/A no ack");
    rd(4'd1, D4[63:0] | MASK, "R7 not captured");
    cyc(0,1,0, 1,0,0,0, D1, 4'b0000); rd(4'd0, 64'h18, "R7 write no ack");
    tag = "R8";
    cyc(1,0,0, 1,0,0,1, D2, 4'b0000); rd(4'd1, D2[63:0] | MASK, "R8 missed bits do not freeze");

    tag = "R10";
    quiet(); diag_err = 1; step(); quiet();
    rd(4'd0, 64'h38, "R10 diag set");
    cyc(1,0,0, 1,0,0,1, D1, 4'b0000); rd(4'd1, D1[63:0] | MASK, "R10 no freeze");
    wr(6'h3F); rd(4'd0, 64'd0, "R10 cleared");

    tag = "R11";
    rd(4'd2, 64'd0, "R11 unmapped");
    rd(4'd15, 64'd0, "R11 unmapped high");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule